// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is a boundary-scan test access port for a chip. A 16-state controller is clocked by the test clock and steered by the mode input. It selects one of four scan registers and places it between the serial data input and the serial data output. The registers are a 3-bit instruction register, a single-bit bypass stage, a 32-bit identification word and a boundary register of parameterised length. The pads are not part of the block. Their boundary cells appear as parallel vectors: sampled input pins and core-side output data and enables go in, and pad-side output data and enables come out.

Six opcodes are decoded. They select the boundary register in two modes, read the identification word, bypass the chip, hold the outputs from the update latches, or float every output. The unused opcode values behave as bypass. Holding the controller in its reset state forces the identification opcode, so a tester can read the identification word straight after reset without loading an instruction.

Top module: `jtag_tap_ctrl`

## Requirements
- R1: The controller follows the standard 16-state test access port graph on rising test-clock edges. From any state, five rising edges with the mode input high reach Test-Logic-Reset. An active-low asynchronous reset also forces that state.
- R2: While the controller is in Test-Logic-Reset, the active instruction is forced to the identification opcode 001. A data scan made straight after reset therefore returns the identification word, even if a different opcode was active before.
- R3: Capture-IR loads 001 into the instruction shift stage. The stage shifts least significant bit first, so the first three bits out are 1, 0, 0. The opcode shifted in becomes active when the controller leaves Update-IR.
- R4: The opcode map is 000 boundary external test, 001 identification, 010 sample/preload, 011 clamp, 100 high-impedance, 111 bypass. Opcodes 101 and 110 behave exactly as bypass.
- R5: In bypass, the single stage captures 0 in Capture-DR. Each bit shifted in appears on the serial output one test-clock cycle later.
- R6: The identification word has bit 0 = 1, bits 11:1 = manufacturer code 00010100001, bits 27:12 = part number parameter and bits 31:28 = version parameter. It is loaded in Capture-DR and shifted out least significant bit first.
- R7: In sample/preload, Capture-DR loads the boundary register without changing the pads. The pads keep following the core data and enables. Update-DR copies the shifted contents into the update latches.
- R8: In external test, pad data and enables come from the update latches. Capture-DR samples the input pins into the input cells.
- R9: In clamp, pad data and enables come from the update latches, and the bypass stage is the scan path.
- R10: In high-impedance, every pad enable is 0 and the bypass stage is the scan path.
- R11: The serial output changes only on falling test-clock edges. Its enable is 1 only after a falling edge in Shift-IR or Shift-DR, and 0 otherwise.
- R12: Boundary register bit 0 is nearest the serial output. Bits NUM_IN-1:0 are the input cells. The next NUM_OUT bits are the output data cells. The top NUM_OUT bits are the output enable cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Active-low asynchronous test reset |
| tms_i | input | 1 | Test mode select |
| tdi_i | input | 1 | Serial test data in |
| tdo_o | output | 1 | Serial test data out, updated on falling edge |
| tdo_oe_o | output | 1 | Enable for the serial data out |
| pin_in_i | input | NUM_IN | Values sampled at the input pins |
| core_out_i | input | NUM_OUT | Output data from the core |
| core_oe_i | input | NUM_OUT | Output enables from the core |
| pad_out_o | output | NUM_OUT | Output data toward the pads |
| pad_oe_o | output | NUM_OUT | Output enables toward the pads |

## Verification
Random pin, core and preload vectors under sample/preload show the difference between capturing into the scan path and disturbing the pads. The same vectors under external test show that the pads take the update latches and that capture samples the pins. Each opcode, including the two unused values, is applied with random latch contents. This tells the latch-driven, floating and core-driven pad modes apart, and the scan-path length (one bit or the full register) separates bypass from boundary selection. Directed scans cover the identification word after reset, the instruction capture pattern, recovery by five mode-high clocks from inside a shift, and the falling-edge timing of the serial output.

// File: rtl/jtag_tap_pkg.sv
`timescale 1ns/1ps
package jtag_tap_pkg;
  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  localparam int IR_W = 3;
  localparam logic [IR_W-1:0] OP_EXTEST = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPLE = 3'b010;
  localparam logic [IR_W-1:0] OP_CLAMP  = 3'b011;
  localparam logic [IR_W-1:0] OP_HIGHZ  = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

  typedef enum logic [1:0] {SEL_BYP, SEL_ID, SEL_BSR} dr_sel_e;

  typedef struct packed {
    dr_sel_e dr_sel;
    logic    pad_ext;
    logic    pad_hiz;
  } ir_dec_t;

  function automatic ir_dec_t decode_ir(logic [IR_W-1:0] op);
    ir_dec_t d;
    d = '{dr_sel: SEL_BYP, pad_ext: 1'b0, pad_hiz: 1'b0};
    case (op)
      OP_EXTEST: begin d.dr_sel = SEL_BSR; d.pad_ext = 1'b1; end
      OP_SAMPLE: d.dr_sel = SEL_BSR;
      OP_IDCODE: d.dr_sel = SEL_ID;
      OP_CLAMP:  d.pad_ext = 1'b1;
      OP_HIGHZ:  d.pad_hiz = 1'b1;
      default:   d.dr_sel = SEL_BYP;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/jtag_tap_fsm.sv
`timescale 1ns/1ps
module jtag_tap_fsm
  import jtag_tap_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  output tap_state_e state_o
);
  tap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_TLR:    state_d = tms_i ? ST_TLR    : ST_RTI;
      ST_RTI:    state_d = tms_i ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: state_d = tms_i ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = tms_i ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  state_d = tms_i ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: state_d = tms_i ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: state_d = tms_i ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: state_d = tms_i ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: state_d = tms_i ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: state_d = tms_i ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: state_d = tms_i ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  state_d = tms_i ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: state_d = tms_i ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: state_d = tms_i ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: state_d = tms_i ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: state_d = tms_i ? ST_SEL_DR : ST_RTI;
      default:   state_d = ST_TLR;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni)
    if (!rst_ni) state_q <= ST_TLR;
    else         state_q <= state_d;

  assign state_o = state_q;

  // run length of tms high, saturating at 5
  logic [2:0] tms_run_q;
  always_ff @(posedge tck_i or negedge rst_ni)
    if (!rst_ni)              tms_run_q <= 3'd0;
    else if (!tms_i)          tms_run_q <= 3'd0;
    else if (tms_run_q != 3'd5) tms_run_q <= tms_run_q + 3'd1;

  AST_FIVE_TMS_RESET: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (tms_run_q == 3'd5) |-> (state_q == ST_TLR)); // R1
  AST_TLR_HOLD: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_q == ST_TLR && tms_i) |=> (state_q == ST_TLR)); // R1
endmodule

// File: rtl/jtag_ir.sv
`timescale 1ns/1ps
module jtag_ir
  import jtag_tap_pkg::*;
(
  input  logic            tck_i,
  input  logic            rst_ni,
  input  tap_state_e      state_i,
  input  logic            tdi_i,
  output logic [IR_W-1:0] ir_o,
  output logic            so_o
);
  logic [IR_W-1:0] sr_q, ir_q;

  always_ff @(posedge tck_i or negedge rst_ni)
    if (!rst_ni) sr_q <= IR_CAPTURE;
    else if (state_i == ST_CAP_IR) sr_q <= IR_CAPTURE;
    else if (state_i == ST_SH_IR)  sr_q <= {tdi_i, sr_q[IR_W-1:1]};

  always_ff @(posedge tck_i or negedge rst_ni)
    if (!rst_ni) ir_q <= OP_IDCODE;
    else if (state_i == ST_TLR)    ir_q <= OP_IDCODE;
    else if (state_i == ST_UPD_IR) ir_q <= sr_q;

  assign ir_o = ir_q;
  assign so_o = sr_q[0];

  AST_IR_STABLE: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i != ST_UPD_IR && state_i != ST_TLR) |=> $stable(ir_q)); // R3
  AST_IR_CAP_LSB: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == ST_CAP_IR) |=> (sr_q[1:0] == 2'b01)); // R3
endmodule

// File: rtl/jtag_bsr.sv
`timescale 1ns/1ps
module jtag_bsr #(
  parameter int NUM_IN  = 8,
  parameter int NUM_OUT = 8,
  localparam int BSR_W  = NUM_IN + 2*NUM_OUT
) (
  input  logic               tck_i,
  input  logic               rst_ni,
  input  logic               cap_en_i,
  input  logic               sh_en_i,
  input  logic               upd_en_i,
  input  logic               tdi_i,
  input  logic               pad_ext_i,
  input  logic               pad_hiz_i,
  input  logic [NUM_IN-1:0]  pin_in_i,
  input  logic [NUM_OUT-1:0] core_out_i,
  input  logic [NUM_OUT-1:0] core_oe_i,
  output logic               so_o,
  output logic [NUM_OUT-1:0] pad_out_o,
  output logic [NUM_OUT-1:0] pad_oe_o
);
  logic [BSR_W-1:0] sr_q, cap_vec;
  logic [NUM_OUT-1:0] lat_out_q, lat_oe_q;

  assign cap_vec = {core_oe_i, core_out_i, pin_in_i};

  always_ff @(posedge tck_i or negedge rst_ni)
    if (!rst_ni)       sr_q <= '0;
    else if (cap_en_i) sr_q <= cap_vec;
    else if (sh_en_i)  sr_q <= {tdi_i, sr_q[BSR_W-1:1]};

  // update latches and pad muxes, one slice per output pin
  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out_cell
    always_ff @(posedge tck_i or negedge rst_ni)
      if (!rst_ni) begin
        lat_out_q[g] <= 1'b0;
        lat_oe_q[g]  <= 1'b0;
      end else if (upd_en_i) begin
        lat_out_q[g] <= sr_q[NUM_IN + g];
        lat_oe_q[g]  <= sr_q[NUM_IN + NUM_OUT + g];
      end
    assign pad_out_o[g] = pad_ext_i ? lat_out_q[g] : core_out_i[g];
    assign pad_oe_o[g]  = pad_hiz_i ? 1'b0 : (pad_ext_i ? lat_oe_q[g] : core_oe_i[g]);
  end

  assign so_o = sr_q[0];

  AST_LATCH_HOLD: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !upd_en_i |=> ($stable(lat_out_q) && $stable(lat_oe_q))); // R7
  AST_SHIFT_ADV: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (sh_en_i && !cap_en_i) |=> (sr_q[BSR_W-1] == $past(tdi_i))); // R12
endmodule

// File: rtl/jtag_tap_ctrl.sv
`timescale 1ns/1ps
module jtag_tap_ctrl
  import jtag_tap_pkg::*;
#(
  parameter int          NUM_IN   = 8,
  parameter int          NUM_OUT  = 8,
  parameter logic [15:0] PART_NUM = 16'h5A3C,
  parameter logic [3:0]  VERSION  = 4'h2,
  parameter logic [10:0] MFR_CODE = 11'b00010100001
) (
  input  logic               tck_i,
  input  logic               rst_ni,
  input  logic               tms_i,
  input  logic               tdi_i,
  output logic               tdo_o,
  output logic               tdo_oe_o,
  input  logic [NUM_IN-1:0]  pin_in_i,
  input  logic [NUM_OUT-1:0] core_out_i,
  input  logic [NUM_OUT-1:0] core_oe_i,
  output logic [NUM_OUT-1:0] pad_out_o,
  output logic [NUM_OUT-1:0] pad_oe_o
);
  localparam logic [31:0] ID_WORD = {VERSION, PART_NUM, MFR_CODE, 1'b1};

  tap_state_e      state;
  logic [IR_W-1:0] ir;
  logic            ir_so, bsr_so, dr_so;
  ir_dec_t         dec;
  logic            cap_dr, sh_dr, upd_dr;
  logic            byp_q;
  logic [31:0]     id_q;
  logic            tdo_q, tdo_oe_q;

  jtag_tap_fsm u_fsm (
    .tck_i, .rst_ni, .tms_i, .state_o(state)
  );

  jtag_ir u_ir (
    .tck_i, .rst_ni, .state_i(state), .tdi_i, .ir_o(ir), .so_o(ir_so)
  );

  assign dec    = decode_ir(ir);
  assign cap_dr = (state == ST_CAP_DR);
  assign sh_dr  = (state == ST_SH_DR);
  assign upd_dr = (state == ST_UPD_DR);

  jtag_bsr #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_bsr (
    .tck_i, .rst_ni,
    .cap_en_i (cap_dr && dec.dr_sel == SEL_BSR),
    .sh_en_i  (sh_dr  && dec.dr_sel == SEL_BSR),
    .upd_en_i (upd_dr && dec.dr_sel == SEL_BSR),
    .tdi_i,
    .pad_ext_i(dec.pad_ext),
    .pad_hiz_i(dec.pad_hiz),
    .pin_in_i, .core_out_i, .core_oe_i,
    .so_o     (bsr_so),
    .pad_out_o, .pad_oe_o
  );

  always_ff @(posedge tck_i or negedge rst_ni)
    if (!rst_ni) byp_q <= 1'b0;
    else if (dec.dr_sel == SEL_BYP) begin
      if (cap_dr)     byp_q <= 1'b0;
      else if (sh_dr) byp_q <= tdi_i;
    end

  always_ff @(posedge tck_i or negedge rst_ni)
    if (!rst_ni) id_q <= ID_WORD;
    else if (dec.dr_sel == SEL_ID) begin
      if (cap_dr)     id_q <= ID_WORD;
      else if (sh_dr) id_q <= {tdi_i, id_q[31:1]};
    end

  always_comb
    unique case (dec.dr_sel)
      SEL_ID:  dr_so = id_q[0];
      SEL_BSR: dr_so = bsr_so;
      default: dr_so = byp_q;
    endcase

  // serial output launched on the falling edge
  always_ff @(negedge tck_i or negedge rst_ni)
    if (!rst_ni) begin
      tdo_q    <= 1'b0;
      tdo_oe_q <= 1'b0;
    end else begin
      tdo_oe_q <= (state == ST_SH_IR) || sh_dr;
      if (state == ST_SH_IR) tdo_q <= ir_so;
      else if (sh_dr)        tdo_q <= dr_so;
    end

  assign tdo_o    = tdo_q;
  assign tdo_oe_o = tdo_oe_q;

  AST_BYP_CAPTURE_ZERO: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (cap_dr && dec.dr_sel == SEL_BYP) |=> (byp_q == 1'b0)); // R5
  AST_ID_LSB_ONE: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (cap_dr && dec.dr_sel == SEL_ID) |=> (id_q[0] == 1'b1)); // R6
  AST_HIGHZ_NO_DRIVE: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (ir == OP_HIGHZ) |-> (pad_oe_o == '0)); // R10
  AST_TDO_EN_SHIFT: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state != ST_SH_IR && state != ST_SH_DR && $past(state) != ST_SH_IR
     && $past(state) != ST_SH_DR) |-> !tdo_oe_o); // R11
endmodule

// File: tb/jtag_tap_ctrl_bench.sv
`timescale 1ns/1ps
module jtag_tap_ctrl_bench;
  localparam int NI = 8;
  localparam int NO = 8;
  localparam int BW = NI + 2*NO;
  localparam logic [31:0] ID_EXP = {4'h2, 16'h5A3C, 11'b00010100001, 1'b1};

  logic tck = 1'b0, rst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo, tdo_oe;
  logic [NI-1:0] pin_in = '0;
  logic [NO-1:0] core_out = '0, core_oe = '0, pad_out, pad_oe;
  int n_vec = 0, n_fail = 0;

  always #4 tck = ~tck;

  jtag_tap_ctrl u_jtag_tap_ctrl (
    .tck_i(tck), .rst_ni(rst_n), .tms_i(tms), .tdi_i(tdi),
    .tdo_o(tdo), .tdo_oe_o(tdo_oe),
    .pin_in_i(pin_in), .core_out_i(core_out), .core_oe_i(core_oe),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  // from Run-Test/Idle, scan n bits through the DR path, back to Run-Test/Idle
  task automatic scan_dr(input logic [63:0] din, input int n, output logic [63:0] dout);
    dout = '0;
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      step(i == n-1, din[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic scan_ir(input logic [2:0] op, output logic [2:0] dout);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 3; i++) begin
      dout[i] = tdo;
      step(i == 2, op[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  function automatic logic [2*NO-1:0] exp_pads(input logic [2:0] op, input logic [BW-1:0] lat,
                                               input logic [NO-1:0] co, input logic [NO-1:0] ce);
    logic [NO-1:0] o, e;
    o = co; e = ce;
    if (op == 3'b000 || op == 3'b011) begin
      o = lat[NI +: NO]; e = lat[NI+NO +: NO];
    end
    if (op == 3'b100) e = '0;
    return {e, o};
  endfunction

  function automatic int exp_len(input logic [2:0] op);
    if (op == 3'b000 || op == 3'b010) return BW;
    if (op == 3'b001) return 32;
    return 1;
  endfunction

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] d, q;
    logic [2:0]  iq;
    logic [BW-1:0] lat;
    void'($urandom(32'h1CE5EED));
    core_out = 8'hA5; core_oe = 8'h3C;
    #20 rst_n = 1'b1;
    @(negedge tck); #1;
    // reset state
    chk("R11 tdo_oe after reset", tdo_oe, 0);
    chk("R4 pads follow core after reset", {pad_oe, pad_out}, {core_oe, core_out});
    step(0, 0);
    chk("R11 tdo_oe in idle", tdo_oe, 0);
    // ID word straight after reset
    scan_dr(64'h0, 32, q);
    chk("R2 R6 id after reset", q[31:0], ID_EXP);
    // IR capture pattern and load BYPASS
    scan_ir(3'b111, iq);
    chk("R3 ir capture pattern", iq, 3'b001);
    // bypass one-cycle delay with falling-edge timing
    d = 64'h0000_0000_B3C5_9A17;
    scan_dr(d, 40, q);
    chk("R5 bypass capture bit", q[0], 0);
    chk("R5 bypass delay", q[39:1], d[38:0]);
    // R11: tdo does not move at the rising edge
    step(1, 0); step(0, 0); step(0, 0);
    chk("R11 tdo_oe in shift", tdo_oe, 1);
    step(0, 1);
    begin
      logic t0;
      t0 = tdo;
      tms = 0; tdi = 0;
      @(posedge tck); #1;
      chk("R11 tdo held past rising edge", tdo, t0);
      @(negedge tck); #1;
      chk("R11 tdo updates on falling edge", tdo, 0);
    end
    // R1: five mode-high clocks from inside Shift-DR, IR forced back to ID (R2)
    for (int i = 0; i < 5; i++) step(1, 0);
    step(0, 0);
    scan_dr(64'h0, 32, q);
    chk("R1 R2 id after tms reset", q[31:0], ID_EXP);
    // directed SAMPLE/PRELOAD then EXTEST
    scan_ir(3'b010, iq);
    pin_in = 8'h5E; core_out = 8'h81; core_oe = 8'hF0;
    lat = 24'hC3_96_00;
    scan_dr({40'h0, lat}, BW, q);
    chk("R7 R12 sample capture layout", q[BW-1:0], {core_oe, core_out, pin_in});
    chk("R7 pads undisturbed", {pad_oe, pad_out}, {core_oe, core_out});
    scan_ir(3'b000, iq);
    chk("R8 extest drives latches", {pad_oe, pad_out}, {lat[NI+NO +: NO], lat[NI +: NO]});
    pin_in = 8'h27;
    scan_dr({40'h0, lat}, BW, q);
    chk("R8 extest captures pins", q[NI-1:0], pin_in);
    // random mix
    for (int it = 0; it < 24; it++) begin
      logic [2:0] op;
      pin_in = $urandom; core_out = $urandom; core_oe = $urandom;
      lat = $urandom;
      scan_ir(3'b010, iq);
      scan_dr({40'h0, lat}, BW, q);
      chk("R7 random sample capture", q[BW-1:0], {core_oe, core_out, pin_in});
      op = it[2:0];
      scan_ir(op, iq);
      chk("R4 R8 R9 R10 random pads", {pad_oe, pad_out}, exp_pads(op, lat, core_out, core_oe));
      // scan-path length check: marker bit lands after exp_len cycles
      d = 64'h1;
      scan_dr(d, 34 + BW, q);
      if (exp_len(op) == 1)
        chk("R4 R5 R9 R10 one-bit path", q[1], 1);
      else if (exp_len(op) == 32)
        chk("R6 id path", {q[32], q[31:0]}, {1'b1, ID_EXP});
      else
        chk("R12 boundary path", {q[BW], q[NI-1:0]}, {1'b1, pin_in});
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule